// File: doc/BRIEF.md
# Deterministic-Latency Multi-Lane Release Buffer

This block sits on the receive side of a multi-lane serial link, after word alignment. Each lane pushes its aligned words into a private FIFO as they arrive. The lanes arrive with different and varying delays. A local multiframe phase counter is re-zeroed by a SYSREF pulse. All lanes are then released together at a programmable offset, counted in frame clocks from the multiframe boundary. Because this release point is the same on every start, the end-to-end latency is the same on every start, even when the link delay exceeds one multiframe.

After release, every lane is drained in lockstep, one word per frame clock. The block captures the boundary-relative phase at which each lane first delivered data, so that software can place the release point outside the arrival window. Three sticky flags are provided:
- a release opportunity was missed because some but not all lanes had arrived;
- a SYSREF arrived out of phase after release;
- a lane FIFO overflowed.

Top module: `lane_release_buf`

## Requirements
- R1: After reset, `out_valid`, `late_err`, `phase_err` and every `ovf_err` bit are 0, and `mf_phase` is 0.
- R2: The effective multiframe length K is `cfg_k`, with 0 read as 1 and values above 32 read as 32. `mf_phase` counts 0..K-1 and wraps to 0. While the buffer is not released, a SYSREF high on an edge makes `mf_phase` 0 after that edge.
- R3: Lane writes are dropped until the first SYSREF after reset or resync. Each lane's first accepted write latches the current `mf_phase` into that lane's field of `arr_phase` (lane i at bits i*5 +: 5).
- R4: The release slot is the cycle whose `mf_phase` equals min(`cfg_rbd`, K-1). The slot counts only when every lane had already written before that cycle. `out_valid` rises on the edge ending that cycle.
- R5: At a release slot where some, but not all, lanes have arrived, no release happens and the sticky `late_err` is set. Release waits for a later multiframe.
- R6: While `out_valid` is high, every lane pops one word per clock. Lane i's slice `out_data[i*16 +: 16]` presents that lane's words in arrival order, starting with its first accepted word.
- R7: Each lane FIFO holds 64 words. A write into a full FIFO is discarded and sets that lane's `ovf_err` bit. The bit is cleared only by reset.
- R8: After release, a SYSREF that does not fall in the cycle with `mf_phase` = K-1 sets the sticky `phase_err`. A SYSREF after release never re-zeroes the counter.
- R9: `resync_req` empties all FIFOs, clears arrival state, `late_err`, `phase_err` and `out_valid`, and waits for a new SYSREF. It leaves `ovf_err` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_valid | input | 4 | Per-lane write strobe |
| lane_data | input | 64 | Per-lane aligned words, 16 bits each |
| sysref | input | 1 | Single-cycle alignment pulse |
| resync_req | input | 1 | Return to waiting for SYSREF and flush |
| cfg_k | input | 6 | Multiframe length in frame clocks |
| cfg_rbd | input | 5 | Release offset from the boundary |
| out_valid | output | 1 | Lanes released, output words valid |
| out_data | output | 64 | Per-lane head words |
| mf_phase | output | 5 | Current multiframe phase |
| arr_phase | output | 20 | Per-lane captured arrival phase |
| ovf_err | output | 4 | Sticky per-lane overflow |
| late_err | output | 1 | Sticky missed-release flag |
| phase_err | output | 1 | Sticky out-of-phase SYSREF flag |

## Verification
The assertions take three things for granted:
- SYSREF is a clean single-cycle pulse.
- `cfg_k` and `cfg_rbd` are only changed while the block is waiting for SYSREF.
- Once a lane starts delivering data, it writes on every frame clock, so no lane FIFO runs dry while draining.

The stimulus keeps within these limits. It streams each lane continuously from its chosen start time. It changes configuration only right after a resync. It places SYSREF pulses at phases taken from its own model of the counter. The overflow case is reached by withholding two lanes, so that release never happens while the other lanes keep writing.

// File: rtl/elb_pkg.sv
package elb_pkg;
  localparam int KMAX = 32;
  localparam int PW   = $clog2(KMAX);
  localparam int KW   = PW + 1;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_ARM  = 2'd1,
    ST_RUN  = 2'd2
  } rel_state_e;

  // Fold the configured multiframe length into 1..KMAX.
  function automatic logic [KW-1:0] fold_k(input logic [KW-1:0] raw);
    if (raw == '0) return KW'(1);
    if (raw > KW'(KMAX)) return KW'(KMAX);
    return raw;
  endfunction

  // Clamp the release offset into 0..k-1.
  function automatic logic [PW-1:0] clamp_rbd(input logic [PW-1:0] rbd,
                                              input logic [KW-1:0] k);
    logic [KW-1:0] last;
    last = k - KW'(1);
    if ({1'b0, rbd} > last) return last[PW-1:0];
    return rbd;
  endfunction
endpackage

// File: rtl/mf_phase.sv
module mf_phase
  import elb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [KW-1:0] cfg_k,
  input  logic          sysref,
  input  logic          realign_ok,
  output logic [PW-1:0] phase,
  output logic          at_last
);
  logic [KW-1:0] k_eff;
  logic          realign;

  assign k_eff   = fold_k(cfg_k);
  assign at_last = ({1'b0, phase} >= (k_eff - KW'(1)));
  assign realign = sysref & realign_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= '0;
    else if (realign) phase <= '0;
    else if (at_last) phase <= '0;
    else              phase <= phase + PW'(1);
  end

  // R2: an accepted SYSREF zeroes the phase on the following cycle
  a_r2_realign_zero: assert property (@(posedge clk) disable iff (!rst_n)
    realign |=> phase == '0);

  // R2: between boundaries the phase advances by one
  a_r2_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (!realign && !at_last) |=> phase == $past(phase) + PW'(1));
endmodule

// File: rtl/lane_slot.sv
module lane_slot #(
  parameter int DW    = 16,
  parameter int DEPTH = 64,
  parameter int PW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          accept,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [PW-1:0] phase,
  output logic [DW-1:0] rd_data,
  output logic          arrived,
  output logic [PW-1:0] arr_phase,
  output logic          ovf
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] fill;
  logic          full, empty, push_try, push, pop;

  assign full     = (fill == CW'(DEPTH));
  assign empty    = (fill == '0);
  assign push_try = accept & wr_en;
  assign push     = push_try & ~full;
  assign pop      = rd_en & ~empty;
  assign rd_data  = mem[rp];

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; fill <= '0; arrived <= 1'b0; arr_phase <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; fill <= '0; arrived <= 1'b0;
    end else begin
      wp   <= wp + AW'(push);
      rp   <= rp + AW'(pop);
      fill <= fill + CW'(push) - CW'(pop);
      if (push_try && !arrived) begin
        arrived   <= 1'b1;
        arr_phase <= phase;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ovf <= 1'b0;
    else if (push_try && full) ovf <= 1'b1;
  end

  // R7: a write into a full FIFO leaves it full (word dropped, not stored)
  a_r7_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_try && !rd_en && !flush) |=> fill == CW'(DEPTH));

  // R7: overflow is sticky
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  // R9: flush empties the lane and forgets its arrival
  a_r9_flush_clear: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (fill == '0) && !arrived);
endmodule

// File: rtl/lane_release_buf.sv
module lane_release_buf
  import elb_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DW    = 16,
  parameter int DEPTH = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LANES-1:0]    lane_valid,
  input  logic [LANES*DW-1:0] lane_data,
  input  logic                sysref,
  input  logic                resync_req,
  input  logic [KW-1:0]       cfg_k,
  input  logic [PW-1:0]       cfg_rbd,
  output logic                out_valid,
  output logic [LANES*DW-1:0] out_data,
  output logic [PW-1:0]       mf_phase,
  output logic [LANES*PW-1:0] arr_phase,
  output logic [LANES-1:0]    ovf_err,
  output logic                late_err,
  output logic                phase_err
);
  rel_state_e     st;
  logic           at_last;
  logic [LANES-1:0] arrived;
  logic [KW-1:0]  k_eff;
  logic [PW-1:0]  rel_at;
  logic           rel_slot, all_in, any_in, rel_fire, slot_missed, phase_slip;
  logic           accept, drain, realign_ok;

  assign k_eff       = fold_k(cfg_k);
  assign rel_at      = clamp_rbd(cfg_rbd, k_eff);
  assign realign_ok  = (st != ST_RUN);
  assign accept      = (st != ST_HUNT);
  assign drain       = (st == ST_RUN);
  assign all_in      = &arrived;
  assign any_in      = |arrived;
  assign rel_slot    = (st == ST_ARM) && (mf_phase == rel_at);
  assign rel_fire    = rel_slot & all_in;
  assign slot_missed = rel_slot & any_in & ~all_in;
  assign phase_slip  = (st == ST_RUN) & sysref & ~at_last;
  assign out_valid   = drain;

  mf_phase u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_k      (cfg_k),
    .sysref     (sysref),
    .realign_ok (realign_ok),
    .phase      (mf_phase),
    .at_last    (at_last)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lane_slot #(.DW(DW), .DEPTH(DEPTH), .PW(PW)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (resync_req),
      .accept    (accept),
      .wr_en     (lane_valid[g]),
      .wr_data   (lane_data[g*DW +: DW]),
      .rd_en     (drain),
      .phase     (mf_phase),
      .rd_data   (out_data[g*DW +: DW]),
      .arrived   (arrived[g]),
      .arr_phase (arr_phase[g*PW +: PW]),
      .ovf       (ovf_err[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          st <= ST_HUNT;
    else if (resync_req) st <= ST_HUNT;
    else begin
      case (st)
        ST_HUNT: if (sysref)   st <= ST_ARM;
        ST_ARM:  if (rel_fire) st <= ST_RUN;
        default: st <= st;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      late_err  <= 1'b0;
      phase_err <= 1'b0;
    end else if (resync_req) begin
      late_err  <= 1'b0;
      phase_err <= 1'b0;
    end else begin
      if (slot_missed) late_err  <= 1'b1;
      if (phase_slip)  phase_err <= 1'b1;
    end
  end

  // R4: output only turns on right after a qualified release slot
  a_r4_release_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(rel_slot && all_in));

  // R6: lockstep drain only with every lane present
  a_r6_all_present: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> all_in);

  // R5: a partial arrival at the slot blocks release and raises the flag
  a_r5_missed_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_missed && !resync_req) |=> late_err && !out_valid);

  // R8: an out-of-phase SYSREF after release is flagged, phase not re-zeroed
  a_r8_slip_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_slip && !resync_req) |=> phase_err && (mf_phase != '0 || $past(at_last)));

  // R9: resync drops the output and clears the sticky link flags
  a_r9_resync_clear: assert property (@(posedge clk) disable iff (!rst_n)
    resync_req |=> !out_valid && !late_err && !phase_err);
endmodule

// File: tb/tb_lane_release_buf.sv
module tb_lane_release_buf;
  localparam int LANES = 4, DW = 16, DEPTH = 64, PW = 5, KW = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                rst_n;
  logic [LANES-1:0]    lane_valid;
  logic [LANES*DW-1:0] lane_data;
  logic                sysref, resync_req;
  logic [KW-1:0]       cfg_k;
  logic [PW-1:0]       cfg_rbd;
  logic                out_valid, late_err, phase_err;
  logic [LANES*DW-1:0] out_data;
  logic [PW-1:0]       mf_phase;
  logic [LANES*PW-1:0] arr_phase;
  logic [LANES-1:0]    ovf_err;

  lane_release_buf #(.LANES(LANES), .DW(DW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .lane_valid(lane_valid), .lane_data(lane_data),
    .sysref(sysref), .resync_req(resync_req), .cfg_k(cfg_k), .cfg_rbd(cfg_rbd),
    .out_valid(out_valid), .out_data(out_data), .mf_phase(mf_phase),
    .arr_phase(arr_phase), .ovf_err(ovf_err), .late_err(late_err),
    .phase_err(phase_err)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // stream control
  bit on [LANES];
  int seq [LANES];

  // behavioural reference
  int m_cnt, m_st;
  bit m_arr [LANES];
  int m_aph [LANES];
  bit m_ovf [LANES];
  bit m_late, m_perr;
  logic [DW-1:0] m_q [LANES][$];

  function automatic int eff_len(input int raw);
    if (raw < 1) return 1;
    if (raw > 32) return 32;
    return raw;
  endfunction

  always @(posedge clk) begin : ref_model
    int kk, rr, st0;
    int sz [LANES];
    bit allin, anyin;
    if (!rst_n) begin
      m_cnt = 0; m_st = 0; m_late = 0; m_perr = 0;
      for (int i = 0; i < LANES; i++) begin
        m_arr[i] = 0; m_aph[i] = 0; m_ovf[i] = 0; m_q[i].delete();
      end
    end else begin
      kk = eff_len(int'(cfg_k));
      rr = (int'(cfg_rbd) > kk - 1) ? kk - 1 : int'(cfg_rbd);
      st0 = m_st; allin = 1; anyin = 0;
      for (int i = 0; i < LANES; i++) begin
        allin = allin & m_arr[i];
        anyin = anyin | m_arr[i];
        sz[i] = m_q[i].size();
      end
      if (st0 == 2)
        for (int i = 0; i < LANES; i++) if (sz[i] > 0) void'(m_q[i].pop_front());
      if (resync_req) begin
        m_st = 0; m_late = 0; m_perr = 0;
        for (int i = 0; i < LANES; i++) begin m_arr[i] = 0; m_q[i].delete(); end
      end else begin
        if (st0 != 0)
          for (int i = 0; i < LANES; i++)
            if (lane_valid[i]) begin
              if (!m_arr[i]) begin m_arr[i] = 1; m_aph[i] = m_cnt; end
              if (sz[i] >= DEPTH) m_ovf[i] = 1;
              else m_q[i].push_back(lane_data[i*DW +: DW]);
            end
        if (st0 == 1 && m_cnt == rr) begin
          if (allin) m_st = 2;
          else if (anyin) m_late = 1;
        end
        if (st0 == 2 && sysref && !(m_cnt >= kk - 1)) m_perr = 1;
        if (st0 == 0 && sysref) m_st = 1;
      end
      if (sysref && st0 != 2) m_cnt = 0;
      else if (m_cnt >= kk - 1) m_cnt = 0;
      else m_cnt = m_cnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk("R2 mf_phase", 64'(mf_phase), 64'(m_cnt));
    chk("R4 out_valid", 64'(out_valid), 64'(m_st == 2));
    chk("R5 late_err", 64'(late_err), 64'(m_late));
    chk("R8 phase_err", 64'(phase_err), 64'(m_perr));
    for (int i = 0; i < LANES; i++) begin
      chk("R7 ovf_err", 64'(ovf_err[i]), 64'(m_ovf[i]));
      if (m_arr[i]) chk("R3 arr_phase", 64'(arr_phase[i*PW +: PW]), 64'(m_aph[i]));
      if (m_st == 2 && m_q[i].size() > 0)
        chk("R6 out_data", 64'(out_data[i*DW +: DW]), 64'(m_q[i][0]));
    end
  endtask

  task automatic drive(input bit sr, input bit rs);
    sysref = sr; resync_req = rs;
    for (int i = 0; i < LANES; i++) begin
      lane_valid[i] = on[i];
      lane_data[i*DW +: DW] = {4'(i), 12'(seq[i])};
      if (on[i]) seq[i]++;
    end
  endtask

  task automatic cyc(input bit sr, input bit rs);
    @(negedge clk); compare(); drive(sr, rs);
  endtask

  task automatic idle(input int n);
    repeat (n) cyc(0, 0);
  endtask

  task automatic pulse_at(input int ph);
    bit hit = 0;
    while (!hit) begin
      @(negedge clk); compare();
      hit = (m_cnt == ph);
      drive(hit, 0);
    end
  endtask

  task automatic set_on(input bit a, input bit b, input bit c, input bit d);
    on[0] = a; on[1] = b; on[2] = c; on[3] = d;
  endtask

  task automatic resync(input int k, input int rbd);
    set_on(0, 0, 0, 0);
    cfg_k = KW'(k); cfg_rbd = PW'(rbd);
    cyc(0, 1);
    cyc(0, 0);
    // R9: released output and link flags are gone right after resync
    chk("R9 out_valid after resync", 64'(out_valid), 64'(0));
    chk("R9 late_err after resync", 64'(late_err), 64'(0));
    chk("R9 phase_err after resync", 64'(phase_err), 64'(0));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < LANES; i++) begin on[i] = 0; seq[i] = 0; end
    rst_n = 0; sysref = 0; resync_req = 0; lane_valid = '0; lane_data = '0;
    cfg_k = 6'd8; cfg_rbd = 5'd3;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 out_valid", 64'(out_valid), 64'(0));
    chk("R1 flags", 64'({late_err, phase_err, ovf_err}), 64'(0));
    chk("R1 mf_phase", 64'(mf_phase), 64'(0));
    rst_n = 1;

    // R3: writes before SYSREF are dropped
    set_on(1, 1, 1, 1);
    idle(4);
    set_on(0, 0, 0, 0);
    idle(2);
    // K=8, release offset 3, staggered lanes
    cyc(1, 0);
    on[0] = 1; idle(1);
    on[1] = 1; idle(2);
    on[2] = 1; idle(3);
    on[3] = 1; idle(30);
    // R8: in-phase SYSREF after release is accepted silently
    pulse_at(7);
    idle(6);
    chk("R8 matched sysref no error", 64'(phase_err), 64'(0));
    // R8: out-of-phase SYSREF flags
    pulse_at(2);
    idle(6);

    // K=5, offset 9 clamps to 4; lane 3 late
    resync(5, 9);
    cyc(1, 0);
    set_on(1, 1, 1, 0);
    idle(7);
    on[3] = 1;
    idle(30);

    // K=32, offset 31
    resync(32, 31);
    set_on(1, 1, 1, 1);
    cyc(1, 0);
    idle(75);

    // overflow: lanes 2,3 never arrive, lanes 0,1 keep writing; K=0 reads as 1
    resync(0, 0);
    set_on(1, 1, 0, 0);
    cyc(1, 0);
    idle(75);
    chk("R7 overflow lane0", 64'(ovf_err[0]), 64'(1));
    chk("R7 no overflow lane2", 64'(ovf_err[2]), 64'(0));
    resync(1, 0);
    chk("R9 ovf kept across resync", 64'(ovf_err[1:0]), 64'(2'b11));
    set_on(1, 1, 1, 1);
    cyc(1, 0);
    idle(12);
    chk("R4 released with K=1", 64'(out_valid), 64'(1));
    idle(1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule